// File: doc/BRIEF.md
# Banked Data Register File with Pointer-Based Indirection

This block holds the data registers of a small 8-bit controller core whose instructions carry a 5-bit file address. Each cycle it forms one effective address, returns the addressed byte on a combinational read path, and commits at most one write on the rising clock edge. The read and the write in a cycle use the same address, as a read-modify-write instruction does.

A pointer register sits at file address 4. Its bits 6:5 select one of four banks for every access, direct or indirect. Only the upper sixteen file locations (0x10–0x1F) are banked. The lower sixteen are shared, so effective addresses 0x20–0x2F, 0x40–0x4F and 0x60–0x6F fold onto 0x00–0x0F. File address 0 is not storage. It redirects the access to the seven-bit address held in the pointer. An indirect access that lands on location 0 again reads as zero, and a write to it is dropped.

Shared locations 1–3 and 5–7 belong to registers kept outside this block. For these locations the block raises a select output and gives their index, and its own read data is zero. Shared locations 8–15 and all banked locations are plain RAM with no reset.

Top module: `banked_file`

## Requirements
- R1: After reset the pointer register holds zero in its seven stored bits, so reading file address 4 returns 0x80.
- R2: Bit 7 of the pointer always reads as 1. Writing 0x09 to address 4 reads back 0x89, and writing 0xFF reads back 0xFF.
- R3: For a nonzero file address the effective address is {pointer[6:5], address[4:0]}. Locations 0x10–0x1F therefore hold four independent values, one per bank.
- R4: Shared locations 0x08–0x0F are the same storage in every bank. A value written with one bank selected reads back with any other bank selected.
- R5: File address 0 uses pointer[6:0] as the effective address for both reads and writes, including addresses in banks 1 to 3.
- R6: When the effective address of an indirect access folds to shared location 0 (pointer 0x00, 0x20, 0x40 or 0x60), the read returns 0x00, and a write changes neither the pointer nor any RAM location.
- R7: When the folded effective address is shared location 1, 2, 3, 5, 6 or 7, sfr_sel is 1, sfr_idx gives that location number (3 bits), and rd_data is 0x00. A write there changes no location in this block. For every other location sfr_sel is 0.
- R8: rd_data follows the address within the same cycle. A write becomes visible only after the rising clock edge that samples wr_en high.
- R9: A write whose effective address folds to shared location 4 loads the pointer, including an indirect write through pointer values 0x04 or 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the pointer |
| f_addr | input | 5 | File address from the instruction; 0 selects indirection |
| wr_en | input | 1 | Write the addressed location at the next edge |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read from the addressed location (combinational) |
| sfr_sel | output | 1 | Address belongs to an external special register |
| sfr_idx | output | 3 | Shared location number of that external register |

## Verification
Reads are combinational, so rd_data, sfr_sel and sfr_idx are due in the same cycle the address is applied. The bench changes inputs on the falling edge and samples one nanosecond later, before the next rising edge. A write is due one edge later. The write task holds wr_en through exactly one rising edge, and the read that follows samples in the next low phase. One directed case looks at rd_data both before and after that edge, to show that the old value stays until the commit. Each case about ignored writes reads the pointer or the RAM location that the dropped write could have touched.

// File: rtl/banked_file_pkg.sv
package banked_file_pkg;
  typedef enum logic [1:0] {
    RG_NULL = 2'd0,
    RG_SFR  = 2'd1,
    RG_PTR  = 2'd2,
    RG_RAM  = 2'd3
  } region_t;
endpackage

// File: rtl/bfile_addr_map.sv
module bfile_addr_map
  import banked_file_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int HALF_WORDS = 16,
  parameter int GPR_FIRST  = 8,
  parameter int PTR_LOC    = 4,
  localparam int OFF_W  = $clog2(HALF_WORDS),
  localparam int FA_W   = OFF_W + 1,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int EA_W   = FA_W + BANK_W,
  localparam int SHARED_GPR = HALF_WORDS - GPR_FIRST,
  localparam int RAM_DEPTH  = SHARED_GPR + NUM_BANKS * HALF_WORDS,
  localparam int RI_W   = $clog2(RAM_DEPTH)
) (
  input  logic [FA_W-1:0] f_addr,
  input  logic [EA_W-1:0] ptr_q,
  output logic [EA_W-1:0] ea,
  output logic            indirect,
  output region_t         region,
  output logic [RI_W-1:0] ram_idx
);
  function automatic logic [EA_W-1:0] form_ea(input logic [FA_W-1:0] fa,
                                               input logic [EA_W-1:0] p);
    if (fa == '0) return p;
    return {p[EA_W-1 -: BANK_W], fa};
  endfunction

  function automatic region_t classify(input logic [EA_W-1:0] a);
    logic [OFF_W-1:0] off;
    off = a[OFF_W-1:0];
    if (a[OFF_W]) return RG_RAM;
    if (off == '0) return RG_NULL;
    if (off == OFF_W'(PTR_LOC)) return RG_PTR;
    if (int'(off) < GPR_FIRST) return RG_SFR;
    return RG_RAM;
  endfunction

  function automatic logic [RI_W-1:0] ram_index(input logic [EA_W-1:0] a);
    logic [OFF_W-1:0] off;
    off = a[OFF_W-1:0];
    if (a[OFF_W])
      return RI_W'(SHARED_GPR) + RI_W'({a[EA_W-1 -: BANK_W], off});
    return RI_W'(off) - RI_W'(GPR_FIRST);
  endfunction

  always_comb begin
    indirect = (f_addr == '0);
    ea       = form_ea(f_addr, ptr_q);
    region   = classify(ea);
    ram_idx  = ram_index(ea);
  end
endmodule

// File: rtl/bfile_ptr_reg.sv
module bfile_ptr_reg #(
  parameter int EA_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [EA_W-1:0] d,
  output logic [EA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bfile_ram.sv
module bfile_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 72,
  localparam int RI_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RI_W-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/banked_file.sv
module banked_file
  import banked_file_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NUM_BANKS  = 4,
  parameter int HALF_WORDS = 16,
  parameter int GPR_FIRST  = 8,
  parameter int PTR_LOC    = 4,
  localparam int OFF_W  = $clog2(HALF_WORDS),
  localparam int FA_W   = OFF_W + 1,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int EA_W   = FA_W + BANK_W,
  localparam int SI_W   = $clog2(GPR_FIRST),
  localparam int RAM_DEPTH = (HALF_WORDS - GPR_FIRST) + NUM_BANKS * HALF_WORDS,
  localparam int RI_W   = $clog2(RAM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FA_W-1:0] f_addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            sfr_sel,
  output logic [SI_W-1:0] sfr_idx
);
  logic [EA_W-1:0] ea;
  logic [EA_W-1:0] ptr_q;
  logic            indirect;
  region_t         region;
  logic [RI_W-1:0] ram_idx;
  logic [DW-1:0]   ram_rdata;

  // Named events for the checker
  logic hit_ram, hit_ptr, indf_null;
  logic wr_ram, wr_ptr;

  bfile_addr_map #(
    .NUM_BANKS(NUM_BANKS), .HALF_WORDS(HALF_WORDS),
    .GPR_FIRST(GPR_FIRST), .PTR_LOC(PTR_LOC)
  ) u_map (
    .f_addr(f_addr), .ptr_q(ptr_q), .ea(ea),
    .indirect(indirect), .region(region), .ram_idx(ram_idx)
  );

  assign hit_ram   = (region == RG_RAM);
  assign hit_ptr   = (region == RG_PTR);
  assign indf_null = (region == RG_NULL);
  assign sfr_sel   = (region == RG_SFR);
  assign sfr_idx   = ea[SI_W-1:0];
  assign wr_ram    = wr_en && hit_ram;
  assign wr_ptr    = wr_en && hit_ptr;

  bfile_ptr_reg #(.EA_W(EA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(wr_ptr),
    .d(wr_data[EA_W-1:0]), .q(ptr_q)
  );

  bfile_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(wr_ram), .idx(ram_idx),
    .wdata(wr_data), .rdata(ram_rdata)
  );

  function automatic logic [DW-1:0] ptr_view(input logic [EA_W-1:0] p);
    logic [DW-1:0] v;
    v = '1;
    v[EA_W-1:0] = p;
    return v;
  endfunction

  always_comb begin
    unique case (region)
      RG_RAM:  rd_data = ram_rdata;
      RG_PTR:  rd_data = ptr_view(ptr_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/banked_file_chk.sv
module banked_file_chk #(
  parameter int DW   = 8,
  parameter int FA_W = 5,
  parameter int EA_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [FA_W-1:0] f_addr,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   rd_data,
  input logic            sfr_sel,
  input logic [EA_W-1:0] ptr_q,
  input logic            hit_ram,
  input logic            hit_ptr,
  input logic            indf_null
);
  p_ptr_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ptr |-> rd_data[DW-1]);

  p_null_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    indf_null |-> (rd_data == '0));

  p_null_write_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && indf_null) |=> $stable(ptr_q));

  p_sfr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> (rd_data == '0));

  p_sfr_write_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sfr_sel) |=> $stable(ptr_q));

  p_ram_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ram) |=>
      (($stable(f_addr) && $stable(ptr_q)) ? (rd_data == $past(wr_data)) : 1'b1));

  p_ptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ptr) |=> (ptr_q == $past(wr_data[EA_W-1:0])));
endmodule

bind banked_file banked_file_chk #(.DW(DW), .FA_W(FA_W), .EA_W(EA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .f_addr(f_addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .sfr_sel(sfr_sel),
  .ptr_q(ptr_q), .hit_ram(hit_ram), .hit_ptr(hit_ptr), .indf_null(indf_null)
);

// File: tb/banked_file_bench.sv
`timescale 1ns/1ps
module banked_file_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] f_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sfr_sel;
  logic [2:0] sfr_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_file u_banked_file (
    .clk(clk), .rst_n(rst_n), .f_addr(f_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sfr_sel(sfr_sel), .sfr_idx(sfr_idx)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    f_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    f_addr = a; wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    rd(5'h04); check("R1 pointer after reset", rd_data, 8'h80);
    rd(5'h00); check("R6 indirect to 0 after reset", rd_data, 8'h00);
  endtask

  task automatic t_ptr_msb;
    wr(5'h04, 8'h09); rd(5'h04); check("R2 pointer 09", rd_data, 8'h89);
    wr(5'h04, 8'hFF); rd(5'h04); check("R2 pointer FF", rd_data, 8'hFF);
    wr(5'h04, 8'h00);
  endtask

  task automatic t_banked;
    for (int b = 0; b < 4; b++) begin
      wr(5'h04, 8'(b << 5));
      wr(5'h1F, 8'(8'h1F + 8'h20 * b));
    end
    for (int b = 0; b < 4; b++) begin
      wr(5'h04, 8'(b << 5));
      rd(5'h1F); check("R3 banked 0x1F", rd_data, 8'(8'h1F + 8'h20 * b));
    end
  endtask

  task automatic t_shared;
    wr(5'h04, 8'h00); wr(5'h0F, 8'h45);
    wr(5'h04, 8'h60); wr(5'h0F, 8'h54);
    wr(5'h04, 8'h40); rd(5'h0F); check("R4 shared 0x0F", rd_data, 8'h54);
    wr(5'h04, 8'h20); rd(5'h08); wr(5'h08, 8'hC3);
    wr(5'h04, 8'h00); rd(5'h08); check("R4 shared 0x08", rd_data, 8'hC3);
  endtask

  task automatic t_indirect;
    wr(5'h04, 8'h00); wr(5'h09, 8'h10);
    wr(5'h04, 8'h09); rd(5'h00); check("R5 indirect read", rd_data, 8'h10);
    wr(5'h00, 8'h15);
    wr(5'h04, 8'h00); rd(5'h09); check("R5 indirect write", rd_data, 8'h15);
    wr(5'h04, 8'h7F); wr(5'h00, 8'h5A);
    wr(5'h04, 8'h60); rd(5'h1F); check("R5 indirect bank3", rd_data, 8'h5A);
  endtask

  task automatic t_null;
    wr(5'h04, 8'h40); rd(5'h00); check("R6 alias 0x40 reads", rd_data, 8'h00);
    check("R6 no sfr_sel", {7'd0, sfr_sel}, 8'h00);
    wr(5'h00, 8'h33); rd(5'h04); check("R6 write dropped ptr", rd_data, 8'hC0);
    wr(5'h04, 8'h00); rd(5'h09); check("R6 write dropped ram", rd_data, 8'h15);
  endtask

  task automatic t_sfr;
    wr(5'h04, 8'h00);
    rd(5'h03); check("R7 sfr_sel at 3", {7'd0, sfr_sel}, 8'h01);
    check("R7 sfr_idx at 3", {5'd0, sfr_idx}, 8'h03);
    check("R7 rd zero at 3", rd_data, 8'h00);
    rd(5'h08); check("R7 no sfr at 8", {7'd0, sfr_sel}, 8'h00);
    wr(5'h04, 8'h25); rd(5'h00);
    check("R7 indirect sfr_sel", {7'd0, sfr_sel}, 8'h01);
    check("R7 indirect sfr_idx", {5'd0, sfr_idx}, 8'h05);
    wr(5'h06, 8'h11); rd(5'h04); check("R7 sfr write no effect", rd_data, 8'hA5);
  endtask

  task automatic t_timing;
    wr(5'h04, 8'h00); wr(5'h12, 8'h11);
    @(negedge clk);
    f_addr = 5'h12; wr_data = 8'hAA; wr_en = 1'b1;
    #1 check("R8 old value before edge", rd_data, 8'h11);
    @(posedge clk);
    #1 wr_en = 1'b0;
    check("R8 new value after edge", rd_data, 8'hAA);
  endtask

  task automatic t_ptr_indirect;
    wr(5'h04, 8'h24); wr(5'h00, 8'h13);
    rd(5'h04); check("R9 indirect ptr load", rd_data, 8'h93);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ptr_msb();
    t_banked();
    t_shared();
    t_indirect();
    t_null();
    t_sfr();
    t_timing();
    t_ptr_indirect();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule